// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD panel and its backlight up and down in a fixed order. Five enables are raised in this order: panel supply, pixel data, backlight supply, backlight PWM, backlight enable. A programmable delay, counted in milliseconds, runs before each one. An active-low LVDS shutdown line is released together with the pixel data enable. A power-off request lowers the same five enables in the opposite order. The delays are reused: the delay that came before a step on the way up is also the wait before that step is removed.

A prescaler divides the system clock into millisecond ticks. It restarts each time a delay is loaded, so every step takes an exact number of clocks: a delay of `D` ms lasts `D*CLKS_PER_MS + 1` clocks, counted from the clock edge that starts it. The step level (how many enables are up) lives in the controller. The controller has four states. `S_OFF` is at rest with nothing on. `S_RISE` is waiting to raise the next step. `S_FULL` is at rest with everything on. `S_FALL` is waiting to lower the highest step.

The controller has these transitions:
- off-to-rise: `S_OFF` goes to `S_RISE` on a power-on request.
- rise-step: `S_RISE` raises one level when its delay ends. It stays in `S_RISE` while levels remain.
- rise-to-full: `S_RISE` goes to `S_FULL` after the fifth step.
- full-to-fall: `S_FULL` goes to `S_FALL` on a power-off request.
- fall-step: `S_FALL` lowers one level when its delay ends.
- fall-to-off: `S_FALL` goes to `S_OFF` after the last step is removed.
- abort: `S_RISE` goes to `S_FALL` on a power-off request, or straight to `S_OFF` if nothing is on yet.
- reverse: `S_FALL` goes to `S_RISE` on a power-on request, or straight to `S_FULL` if all five enables are still on.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is held and after it is released with no request, all five enables are 0, `lvds_shdn_n` is 0 and `pwr_state` is 2'b00.
- R2: After a power-on request from off, the enables rise one at a time in the order panel supply, pixel data, backlight supply, PWM, backlight enable. Step k rises `DLY_k*CLKS_PER_MS + 1` clocks after the edge that started it. That edge is the request edge for the first step and the previous step's edge for every later step.
- R3: A delay of 0 ms makes its step follow the previous one on the very next clock.
- R4: `lvds_shdn_n` is high exactly when the pixel data enable is high.
- R5: A power-off request from fully on lowers the enables in reverse order. Removing step k waits `DLY_k*CLKS_PER_MS + 1` clocks, so backlight enable goes first, after the backlight-enable delay.
- R6: `pwr_state` reads 2'b01 when all five enables are on and the controller is at rest. It reads 2'b00 when none are on and the controller is at rest. It reads 2'b10 while a sequence is running.
- R7: A power-off request during power-up stops the rise with no further step. The power-down then starts from the current level. If no step has risen yet, the block returns to off on the next clock.
- R8: A power-on request during power-up or when fully on, and a power-off request during power-down or when off, have no effect on any output or timing.
- R9: A power-on request during power-down restarts the rise from the current level. The next step takes its normal up delay.
- R10: When power-on and power-off requests arrive in the same clock, power-off wins.
- R11: At most one of the five enables changes in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_on_req | input | 1 | Request to power the panel up |
| pwr_off_req | input | 1 | Request to power the panel down (wins over power-on) |
| panel_vdd_en | output | 1 | Panel supply enable (step 1) |
| pix_data_en | output | 1 | Pixel data enable (step 2) |
| bl_vdd_en | output | 1 | Backlight supply enable (step 3) |
| bl_pwm_en | output | 1 | Backlight PWM enable (step 4) |
| bl_en | output | 1 | Backlight enable (step 5) |
| lvds_shdn_n | output | 1 | LVDS shutdown, active low |
| pwr_state | output | 2 | 00 fully off, 01 fully on, 10 busy |

## Verification
Suppose the step level or the loaded delay index were wrong. An enable would then rise or fall on a clock other than the one the delay formula predicts, and the bench would see it at the first sample after that edge. A wrong controller state shows up in `pwr_state`, or in how a later request is handled, within one clock of that request. The bench sweeps the abort point and the reverse point over every clock of both sequences. That sweep reaches each level and each pending-delay phase.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

    localparam int unsigned NSTEP = 5;

    typedef enum logic [1:0] {
        PS_OFF  = 2'b00,
        PS_ON   = 2'b01,
        PS_BUSY = 2'b10
    } pwr_stat_e;

    typedef enum logic [1:0] {
        S_OFF,
        S_RISE,
        S_FULL,
        S_FALL
    } seq_state_e;

    function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d,
                                         input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/lcd_pwr_tick.sv
module lcd_pwr_tick #(
    parameter int unsigned CLKS_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int unsigned PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(CLKS_PER_MS - 1);

    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
        end else if (en) begin
            if (pre == LAST) pre <= '0;
            else             pre <= pre + 1'b1;
        end
    end

    assign tick = en && (pre == LAST);

endmodule

// File: rtl/lcd_pwr_timer.sv
module lcd_pwr_timer #(
    parameter int unsigned CLKS_PER_MS = 100000,
    parameter int unsigned D0 = 400,
    parameter int unsigned D1 = 4,
    parameter int unsigned D2 = 203,
    parameter int unsigned D3 = 17,
    parameter int unsigned D4 = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [2:0] idx,
    output logic       done
);
    localparam int unsigned DMAX = lcd_pwr_pkg::max5(D0, D1, D2, D3, D4);
    localparam int unsigned MS_W = (DMAX < 1) ? 1 : $clog2(DMAX + 1);

    logic [MS_W-1:0] ms;
    logic [MS_W-1:0] ms_init;
    logic            tick;

    always_comb begin
        case (idx)
            3'd0:    ms_init = MS_W'(D0);
            3'd1:    ms_init = MS_W'(D1);
            3'd2:    ms_init = MS_W'(D2);
            3'd3:    ms_init = MS_W'(D3);
            3'd4:    ms_init = MS_W'(D4);
            default: ms_init = '0;
        endcase
    end

    lcd_pwr_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (load),
        .en   (ms != '0),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst)                    ms <= '0;
        else if (load)              ms <= ms_init;
        else if (tick && ms != '0)  ms <= ms - 1'b1;
    end

    assign done = (ms == '0);

    // R2: without a reload the millisecond count only ever steps down by one
    p_count_steps_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && ms != $past(ms)) |-> (ms == $past(ms) - MS_W'(1)));

endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
    import lcd_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       on_req,
    input  logic       off_req,
    input  logic       tdone,
    output logic       load,
    output logic [2:0] idx,
    output logic [2:0] lvl,
    output pwr_stat_e  stat
);
    seq_state_e state, nstate;
    logic [2:0] nlvl;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_OFF;
            lvl   <= 3'd0;
        end else begin
            state <= nstate;
            lvl   <= nlvl;
        end
    end

    // transitions and delay selection
    always_comb begin
        nstate = state;
        nlvl   = lvl;
        load   = 1'b0;
        idx    = lvl;
        unique case (state)
            S_OFF: begin
                if (!off_req && on_req) begin
                    nstate = S_RISE;
                    load   = 1'b1;
                    idx    = lvl;
                end
            end
            S_RISE: begin
                if (off_req) begin
                    if (lvl == 3'd0) begin
                        nstate = S_OFF;
                    end else begin
                        nstate = S_FALL;
                        load   = 1'b1;
                        idx    = lvl - 3'd1;
                    end
                end else if (tdone) begin
                    nlvl = lvl + 3'd1;
                    if (lvl == 3'(NSTEP - 1)) begin
                        nstate = S_FULL;
                    end else begin
                        load = 1'b1;
                        idx  = lvl + 3'd1;
                    end
                end
            end
            S_FULL: begin
                if (off_req) begin
                    nstate = S_FALL;
                    load   = 1'b1;
                    idx    = lvl - 3'd1;
                end
            end
            S_FALL: begin
                if (on_req && !off_req) begin
                    if (lvl == 3'(NSTEP)) begin
                        nstate = S_FULL;
                    end else begin
                        nstate = S_RISE;
                        load   = 1'b1;
                        idx    = lvl;
                    end
                end else if (tdone) begin
                    nlvl = lvl - 3'd1;
                    if (lvl == 3'd1) begin
                        nstate = S_OFF;
                    end else begin
                        load = 1'b1;
                        idx  = lvl - 3'd2;
                    end
                end
            end
        endcase
    end

    // status output
    always_comb begin
        unique case (state)
            S_OFF:   stat = PS_OFF;
            S_FULL:  stat = PS_ON;
            default: stat = PS_BUSY;
        endcase
    end

    // R2: the step level only moves when the timer reported an expired delay
    p_step_needs_done_r2: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> $past(tdone));

    // R8: a repeated power-on while fully on leaves the block fully on
    p_full_holds_on_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_FULL && on_req && !off_req) |=> (state == S_FULL));

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_pwr_pkg::*;
#(
    parameter int unsigned CLKS_PER_MS   = 100000,
    parameter int unsigned DLY_PANEL_MS  = 400,
    parameter int unsigned DLY_DATA_MS   = 4,
    parameter int unsigned DLY_BLVDD_MS  = 203,
    parameter int unsigned DLY_PWM_MS    = 17,
    parameter int unsigned DLY_BLEN_MS   = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_on_req,
    input  logic       pwr_off_req,
    output logic       panel_vdd_en,
    output logic       pix_data_en,
    output logic       bl_vdd_en,
    output logic       bl_pwm_en,
    output logic       bl_en,
    output logic       lvds_shdn_n,
    output logic [1:0] pwr_state
);
    logic       load;
    logic       tdone;
    logic [2:0] idx;
    logic [2:0] lvl;
    pwr_stat_e  stat;

    lcd_pwr_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .on_req  (pwr_on_req),
        .off_req (pwr_off_req),
        .tdone   (tdone),
        .load    (load),
        .idx     (idx),
        .lvl     (lvl),
        .stat    (stat)
    );

    lcd_pwr_timer #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .D0          (DLY_PANEL_MS),
        .D1          (DLY_DATA_MS),
        .D2          (DLY_BLVDD_MS),
        .D3          (DLY_PWM_MS),
        .D4          (DLY_BLEN_MS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .idx  (idx),
        .done (tdone)
    );

    // rail decode from the step level
    always_comb begin
        panel_vdd_en = (lvl >= 3'd1);
        pix_data_en  = (lvl >= 3'd2);
        bl_vdd_en    = (lvl >= 3'd3);
        bl_pwm_en    = (lvl >= 3'd4);
        bl_en        = (lvl >= 3'd5);
        lvds_shdn_n  = (lvl >= 3'd2);
        pwr_state    = stat;
    end

    // R11: never more than one enable moves per clock
    p_one_change_r11: assert property (@(posedge clk) disable iff (rst)
        $countones({panel_vdd_en, pix_data_en, bl_vdd_en, bl_pwm_en, bl_en} ^
                   $past({panel_vdd_en, pix_data_en, bl_vdd_en, bl_pwm_en, bl_en})) <= 1);

    // R6: fully-on status only with every enable up, fully-off only with all down
    p_on_means_all_r6: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'b01) |-> (panel_vdd_en && pix_data_en && bl_vdd_en && bl_pwm_en && bl_en));

    p_off_means_none_r6: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'b00) |-> !(panel_vdd_en || pix_data_en || bl_vdd_en || bl_pwm_en || bl_en || lvds_shdn_n));

    // R10: both requests together while off keep the block off
    p_off_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'b00 && pwr_on_req && pwr_off_req) |=> (pwr_state == 2'b00));

endmodule

// File: tb/lcd_pwr_seq_test.sv
`timescale 1ns/1ps
module lcd_pwr_seq_test;
    localparam int P    = 3;
    localparam int TSEQ = 26;

    logic clk = 1'b0;
    logic rst;
    logic pon, poff;
    logic panel_vdd_en, pix_data_en, bl_vdd_en, bl_pwm_en, bl_en, lvds_shdn_n;
    logic [1:0] pwr_state;
    logic [4:0] outs_v;

    int nvec = 0;
    int nbad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lcd_pwr_seq #(
        .CLKS_PER_MS  (P),
        .DLY_PANEL_MS (2),
        .DLY_DATA_MS  (0),
        .DLY_BLVDD_MS (1),
        .DLY_PWM_MS   (3),
        .DLY_BLEN_MS  (1)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .pwr_on_req   (pon),
        .pwr_off_req  (poff),
        .panel_vdd_en (panel_vdd_en),
        .pix_data_en  (pix_data_en),
        .bl_vdd_en    (bl_vdd_en),
        .bl_pwm_en    (bl_pwm_en),
        .bl_en        (bl_en),
        .lvds_shdn_n  (lvds_shdn_n),
        .pwr_state    (pwr_state)
    );

    assign outs_v = {bl_en, bl_pwm_en, bl_vdd_en, pix_data_en, panel_vdd_en};

    function automatic int dly(input int k);
        case (k)
            0: return 2;
            1: return 0;
            2: return 1;
            3: return 3;
            default: return 1;
        endcase
    endfunction

    // expected level m edges after an up request from level l0
    function automatic int lvl_up(input int l0, input int m);
        int l = l0;
        int cum = 0;
        for (int k = l0; k < 5; k++) begin
            cum += dly(k) * P + 1;
            if (cum + 1 <= m) l++;
        end
        return l;
    endfunction

    function automatic int lvl_dn(input int l0, input int m);
        int l = l0;
        int cum = 0;
        for (int k = l0 - 1; k >= 0; k--) begin
            cum += dly(k) * P + 1;
            if (cum + 1 <= m) l--;
        end
        return l;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic on, input logic off);
        pon  = on;
        poff = off;
    endtask

    // follow a running sequence for ncyc clocks, checking every sample
    task automatic follow(input bit up, input int l0, input int ncyc, input bit poke,
                          input string tag, output int lend);
        logic [4:0] prev;
        int e;
        int es;
        prev = outs_v;
        e = l0;
        for (int m = 1; m <= ncyc; m++) begin
            @(negedge clk);
            pon  = 1'b0;
            poff = 1'b0;
            e  = up ? lvl_up(l0, m) : lvl_dn(l0, m);
            es = up ? ((e == 5) ? 1 : 2) : ((e == 0) ? 0 : 2);
            check(tag, int'(outs_v), (1 << e) - 1);
            check("R4 lvds", int'(lvds_shdn_n), int'(pix_data_en));
            check("R6 status", int'(pwr_state), es);
            check("R11 one change", ($countones(outs_v ^ prev) <= 1) ? 1 : 0, 1);
            prev = outs_v;
            if (poke && (m % 2 == 0)) begin
                if (up) pon = 1'b1;
                else    poff = 1'b1;
            end
        end
        lend = e;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int l;
        int l2;
        rst = 1'b1;
        pon = 1'b0;
        poff = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset outs", int'(outs_v), 0);
        check("R1 reset lvds", int'(lvds_shdn_n), 0);
        check("R1 reset status", int'(pwr_state), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle outs", int'(outs_v), 0);
        check("R1 idle status", int'(pwr_state), 0);

        // R10: both requests at once from off
        drive(1'b1, 1'b1);
        follow(1'b0, 0, 5, 1'b0, "R10 both requests", l);

        // R2 R3: full rise including the zero-delay step; R5: full fall
        drive(1'b1, 1'b0);
        follow(1'b1, 0, TSEQ + 2, 1'b0, "R2 R3 rise", l);
        drive(1'b0, 1'b1);
        follow(1'b0, l, TSEQ + 2, 1'b0, "R5 fall", l);

        // R7: abort the rise at every clock of it
        for (int n = 1; n <= TSEQ + 1; n++) begin
            drive(1'b1, 1'b0);
            follow(1'b1, 0, n, 1'b0, "R2 rise", l);
            drive(1'b0, 1'b1);
            follow(1'b0, l, TSEQ + 3, 1'b0, "R7 abort", l2);
        end

        // R9: reverse the fall at every clock of it
        drive(1'b1, 1'b0);
        follow(1'b1, 0, TSEQ + 2, 1'b0, "R2 rise", l);
        for (int m = 1; m <= TSEQ + 1; m++) begin
            drive(1'b0, 1'b1);
            follow(1'b0, 5, m, 1'b0, "R5 fall", l);
            drive(1'b1, 1'b0);
            follow(1'b1, l, TSEQ + 3, 1'b0, "R9 reverse", l2);
        end
        drive(1'b0, 1'b1);
        follow(1'b0, 5, TSEQ + 2, 1'b0, "R5 fall", l);

        // R8: same-direction requests repeated through both sequences
        drive(1'b1, 1'b0);
        follow(1'b1, 0, TSEQ + 4, 1'b1, "R8 repeat on", l);
        drive(1'b0, 1'b1);
        follow(1'b0, l, TSEQ + 4, 1'b1, "R8 repeat off", l);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule